// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, from a software-programmed priority table, the most urgent active interrupt source. It reports separately the source steered to the fast interrupt line (FIQ) and the source steered to the normal line (IRQ). The table has 40 slots. Each slot names one source by a 6-bit ID, and a lower slot number means higher priority. Software can therefore place any source at any priority level, and can leave sources out of the table altogether.

The block receives each bank's masked pending vector, meaning pending AND enabled, already computed outside. It also receives each bank's steering vector, which says FIQ or IRQ per source. Bank 0 holds sources 0 to 31 and bank 1 holds sources 32 to 39. The result is a single 32-bit status word that a register read path can return unchanged. The block is purely combinational. It has no stream interface, so every pin is a plain level signal and there is no back-pressure to handle. The word follows its inputs without a clock.

Top module: `pic_pri_resolver`

## Requirements
- R1: When no slot produces a winner for either class, `winner_o` equals 0x003F003F. When only one class lacks a winner, that half alone reads 0x003F.
- R2: A slot whose bit 31 (valid flag) is 0 never produces a winner, whatever its ID and the source vectors.
- R3: A valid slot whose ID (bits 5:0) is 40 or more never produces a winner.
- R4: A qualifying slot's source is FIQ-active when both its masked pending bit and its steering bit are 1. The FIQ winner's ID is placed in `winner_o[5:0]`, and `winner_o[15]` is set to 1.
- R5: A qualifying slot's source is IRQ-active when its masked pending bit is 1 and its steering bit is 0. The IRQ winner's ID is placed in `winner_o[21:16]`, and `winner_o[31]` is set to 1.
- R6: Among the FIQ-active slots, the one with the lowest slot index wins. The IRQ winner is chosen the same way, independently of the FIQ choice.
- R7: IDs 0 to 31 select bit ID of the bank-0 vectors. IDs 32 to 39 select bit ID-32 of the bank-1 vectors.
- R8: When a half has a winner, its bits other than the flag and the ID read 0. The result does not depend on slot bits 30:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_tbl_i | input | 40 x 32 | Priority table; slot n holds valid flag (bit 31) and source ID (bits 5:0) |
| act_lo_i | input | 32 | Masked pending vector, sources 0 to 31 |
| act_hi_i | input | 32 | Masked pending vector, sources 32 to 63 (only bits 7:0 reachable) |
| fiq_sel_lo_i | input | 32 | Steering vector, sources 0 to 31; 1 selects FIQ |
| fiq_sel_hi_i | input | 32 | Steering vector, sources 32 to 63; 1 selects FIQ |
| winner_o | output | 32 | Status word: FIQ result in bits 15:0, IRQ result in bits 31:16 |

## Verification
The block holds no state, so an internal fault has no place to hide. A misqualified slot, a misrouted bank bit or a wrong comparison in the selection tree changes `winner_o` in the same evaluation that presents the input. The fault then shows up as a wrong ID, a missing or spurious flag, or a non-0x3F idle half. The sweeps therefore place every ID in every class and pit slots against each other in random orders. Each expected word comes from a plain slot-by-slot scan.

// File: rtl/pic_pri_pkg.sv
package pic_pri_pkg;
  localparam int PRI_SLOTS   = 40;  // priority table depth
  localparam int PRI_SRCS    = 40;  // number of interrupt sources
  localparam int PRI_BANK_W  = 32;  // sources per bank vector
  localparam int PRI_ID_W    = 6;   // source ID width in a slot
  localparam int PRI_WORD_W  = 32;  // slot word and result word width
  localparam int PRI_VLD_BIT = 31;  // slot valid flag position
endpackage

// File: rtl/pic_slot_qual.sv
// Qualifies one priority slot: decides whether the source it names is
// active as FIQ or as IRQ.
module pic_slot_qual #(
  parameter int WORD_W  = 32,
  parameter int VLD_BIT = 31,
  parameter int ID_W    = 6,
  parameter int NUM_SRC = 40,
  parameter int SRC_W   = 64
) (
  input  logic [WORD_W-1:0] slot_i,
  input  logic [SRC_W-1:0]  act_i,
  input  logic [SRC_W-1:0]  fiq_i,
  output logic              fiq_req_o,
  output logic              irq_req_o,
  output logic [ID_W-1:0]   id_o
);
  localparam int            SPAN    = 1 << ID_W;
  localparam logic [ID_W:0] SRC_LIM = (ID_W+1)'(NUM_SRC);

  logic [SPAN-1:0] act_pad;
  logic [SPAN-1:0] fiq_pad;
  logic            in_range;
  logic            usable;
  logic            src_act;
  logic            src_fiq;

  assign act_pad  = SPAN'(act_i);
  assign fiq_pad  = SPAN'(fiq_i);
  assign id_o     = slot_i[ID_W-1:0];
  assign in_range = ({1'b0, id_o} < SRC_LIM);
  assign usable   = slot_i[VLD_BIT] & in_range;
  assign src_act  = act_pad[id_o];
  assign src_fiq  = fiq_pad[id_o];

  assign fiq_req_o = usable & src_act & src_fiq;
  assign irq_req_o = usable & src_act & ~src_fiq;
endmodule

// File: rtl/pic_first_pick.sv
// Balanced selection tree: returns the ID carried by the lowest-index
// requesting leaf. The left child always holds lower slot numbers.
module pic_first_pick #(
  parameter int N    = 40,
  parameter int ID_W = 6
) (
  input  logic [N-1:0]           req_i,
  input  logic [N-1:0][ID_W-1:0] ids_i,
  output logic                   found_o,
  output logic [ID_W-1:0]        id_o
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
  localparam int P      = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int W = P >> l;
    logic [W-1:0]           v;
    logic [W-1:0][ID_W-1:0] d;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_in
        if (j < N) begin : g_real
          assign v[j] = req_i[j];
          assign d[j] = ids_i[j];
        end else begin : g_pad
          assign v[j] = 1'b0;
          assign d[j] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_cmp
        assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
        assign d[j] = g_lvl[l-1].v[2*j] ? g_lvl[l-1].d[2*j]
                                        : g_lvl[l-1].d[2*j+1];
      end
    end
  end

  assign found_o = g_lvl[LEVELS].v[0];
  assign id_o    = g_lvl[LEVELS].d[0];
endmodule

// File: rtl/pic_word_pack.sv
// Packs the two winners into the status word, with an idle code per half.
module pic_word_pack #(
  parameter int WORD_W = 32,
  parameter int ID_W   = 6
) (
  input  logic              fiq_found_i,
  input  logic [ID_W-1:0]   fiq_id_i,
  input  logic              irq_found_i,
  input  logic [ID_W-1:0]   irq_id_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int                HALF_W = WORD_W / 2;
  localparam int                PAD_W  = HALF_W - 1 - ID_W;
  localparam logic [HALF_W-1:0] NO_WIN = HALF_W'((1 << ID_W) - 1);

  logic [HALF_W-1:0] lo_half;
  logic [HALF_W-1:0] hi_half;

  assign lo_half = fiq_found_i ? {1'b1, {PAD_W{1'b0}}, fiq_id_i} : NO_WIN;
  assign hi_half = irq_found_i ? {1'b1, {PAD_W{1'b0}}, irq_id_i} : NO_WIN;
  assign word_o  = {hi_half, lo_half};
endmodule

// File: rtl/pic_pri_resolver.sv
module pic_pri_resolver
  import pic_pri_pkg::*;
#(
  parameter int NUM_SLOTS = PRI_SLOTS,
  parameter int NUM_SRC   = PRI_SRCS,
  parameter int BANK_W    = PRI_BANK_W,
  parameter int ID_W      = PRI_ID_W,
  parameter int WORD_W    = PRI_WORD_W,
  parameter int VLD_BIT   = PRI_VLD_BIT
) (
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_tbl_i,
  input  logic [BANK_W-1:0]                act_lo_i,
  input  logic [BANK_W-1:0]                act_hi_i,
  input  logic [BANK_W-1:0]                fiq_sel_lo_i,
  input  logic [BANK_W-1:0]                fiq_sel_hi_i,
  output logic [WORD_W-1:0]                winner_o
);
  localparam int SRC_W = 2 * BANK_W;

  logic [SRC_W-1:0]               src_act;
  logic [SRC_W-1:0]               src_fiq;
  logic [NUM_SLOTS-1:0]           fiq_req;
  logic [NUM_SLOTS-1:0]           irq_req;
  logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id;
  logic                           fiq_found;
  logic                           irq_found;
  logic [ID_W-1:0]                fiq_id;
  logic [ID_W-1:0]                irq_id;

  // second bank sits directly above the first: ID 32 reaches hi bit 0
  assign src_act = {act_hi_i, act_lo_i};
  assign src_fiq = {fiq_sel_hi_i, fiq_sel_lo_i};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    pic_slot_qual #(
      .WORD_W (WORD_W),
      .VLD_BIT(VLD_BIT),
      .ID_W   (ID_W),
      .NUM_SRC(NUM_SRC),
      .SRC_W  (SRC_W)
    ) u_qual (
      .slot_i   (slot_tbl_i[s]),
      .act_i    (src_act),
      .fiq_i    (src_fiq),
      .fiq_req_o(fiq_req[s]),
      .irq_req_o(irq_req[s]),
      .id_o     (slot_id[s])
    );
  end

  pic_first_pick #(.N(NUM_SLOTS), .ID_W(ID_W)) u_pick_fiq (
    .req_i  (fiq_req),
    .ids_i  (slot_id),
    .found_o(fiq_found),
    .id_o   (fiq_id)
  );

  pic_first_pick #(.N(NUM_SLOTS), .ID_W(ID_W)) u_pick_irq (
    .req_i  (irq_req),
    .ids_i  (slot_id),
    .found_o(irq_found),
    .id_o   (irq_id)
  );

  pic_word_pack #(.WORD_W(WORD_W), .ID_W(ID_W)) u_pack (
    .fiq_found_i(fiq_found),
    .fiq_id_i   (fiq_id),
    .irq_found_i(irq_found),
    .irq_id_i   (irq_id),
    .word_o     (winner_o)
  );
endmodule

// File: rtl/pic_pri_resolver_chk.sv
module pic_pri_resolver_chk #(
  parameter int BANK_W  = 32,
  parameter int ID_W    = 6,
  parameter int NUM_SRC = 40,
  parameter int WORD_W  = 32
) (
  input logic [BANK_W-1:0] act_lo_i,
  input logic [BANK_W-1:0] act_hi_i,
  input logic [BANK_W-1:0] fiq_sel_lo_i,
  input logic [BANK_W-1:0] fiq_sel_hi_i,
  input logic [WORD_W-1:0] winner_o
);
  localparam int                HALF_W  = WORD_W / 2;
  localparam int                SPAN    = 1 << ID_W;
  localparam logic [HALF_W-1:0] NO_WIN  = HALF_W'((1 << ID_W) - 1);
  localparam logic [ID_W:0]     SRC_LIM = (ID_W+1)'(NUM_SRC);

  logic [SPAN-1:0]   act_pad;
  logic [SPAN-1:0]   fiq_pad;
  logic [HALF_W-1:0] lo_h;
  logic [HALF_W-1:0] hi_h;
  logic [ID_W-1:0]   lo_id;
  logic [ID_W-1:0]   hi_id;

  assign act_pad = SPAN'({act_hi_i, act_lo_i});
  assign fiq_pad = SPAN'({fiq_sel_hi_i, fiq_sel_lo_i});
  assign lo_h    = winner_o[HALF_W-1:0];
  assign hi_h    = winner_o[WORD_W-1:HALF_W];
  assign lo_id   = lo_h[ID_W-1:0];
  assign hi_id   = hi_h[ID_W-1:0];

  always_comb begin
    // R1
    no_win_lo_chk: assert (lo_h[HALF_W-1] || lo_h == NO_WIN)
      else $error("idle FIQ half not 0x3F");
    // R1
    no_win_hi_chk: assert (hi_h[HALF_W-1] || hi_h == NO_WIN)
      else $error("idle IRQ half not 0x3F");
    // R8
    lo_pad_chk: assert (!lo_h[HALF_W-1] || lo_h[HALF_W-2:ID_W] == '0)
      else $error("FIQ half padding not zero");
    // R8
    hi_pad_chk: assert (!hi_h[HALF_W-1] || hi_h[HALF_W-2:ID_W] == '0)
      else $error("IRQ half padding not zero");
    // R3
    id_range_chk: assert ((!lo_h[HALF_W-1] || {1'b0, lo_id} < SRC_LIM) &&
                          (!hi_h[HALF_W-1] || {1'b0, hi_id} < SRC_LIM))
      else $error("winner ID out of source range");
    // R4
    fiq_active_chk: assert (!lo_h[HALF_W-1] || (act_pad[lo_id] && fiq_pad[lo_id]))
      else $error("FIQ winner not FIQ-active");
    // R5
    irq_active_chk: assert (!hi_h[HALF_W-1] || (act_pad[hi_id] && !fiq_pad[hi_id]))
      else $error("IRQ winner not IRQ-active");
  end
endmodule

bind pic_pri_resolver pic_pri_resolver_chk #(
  .BANK_W (BANK_W),
  .ID_W   (ID_W),
  .NUM_SRC(NUM_SRC),
  .WORD_W (WORD_W)
) u_chk (
  .act_lo_i    (act_lo_i),
  .act_hi_i    (act_hi_i),
  .fiq_sel_lo_i(fiq_sel_lo_i),
  .fiq_sel_hi_i(fiq_sel_hi_i),
  .winner_o    (winner_o)
);

// File: tb/tb_pic_pri_resolver.sv
module tb_pic_pri_resolver;
  logic              clk = 1'b0;
  logic [39:0][31:0] tbl;
  logic [31:0]       act_lo, act_hi, sel_lo, sel_hi;
  logic [31:0]       word;
  int                checks = 0;
  int                fails  = 0;
  int                cyc    = 0;
  bit                done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pic_pri_resolver dut (
    .slot_tbl_i  (tbl),
    .act_lo_i    (act_lo),
    .act_hi_i    (act_hi),
    .fiq_sel_lo_i(sel_lo),
    .fiq_sel_hi_i(sel_hi),
    .winner_o    (word)
  );

  // Slot-by-slot scan from the requirements
  function automatic logic [31:0] ref_word();
    logic        fq = 1'b0, iq = 1'b0;
    logic [5:0]  fid = 6'd0, iid = 6'd0;
    logic [15:0] lo, hi;
    for (int i = 0; i < 40; i++) begin
      int  id;
      logic a, s;
      id = int'(tbl[i][5:0]);
      if (tbl[i][31] && id < 40) begin
        a = (id < 32) ? act_lo[id] : act_hi[id-32];
        s = (id < 32) ? sel_lo[id] : sel_hi[id-32];
        if (a && s && !fq) begin fq = 1'b1; fid = 6'(id); end
        if (a && !s && !iq) begin iq = 1'b1; iid = 6'(id); end
      end
    end
    lo = fq ? (16'h8000 | 16'(fid)) : 16'h003F;
    hi = iq ? (16'h8000 | 16'(iid)) : 16'h003F;
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    @(negedge clk);
    #2;
    checks++;
    if (word !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", tag, word, exp);
    end
  endtask

  task automatic clear_all();
    tbl = '0; act_lo = '0; act_hi = '0; sel_lo = '0; sel_hi = '0;
  endtask

  task automatic put_src(input int id, input logic a, input logic s);
    if (id < 32) begin act_lo[id] = a; sel_lo[id] = s; end
    else begin act_hi[id-32] = a; sel_hi[id-32] = s; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    // R1: all-zero inputs, nothing qualifies
    check("R1 idle", 32'h003F003F);
    // R1: valid slots present but nothing pending
    for (int i = 0; i < 40; i++) tbl[i] = 32'h8000_0000 | 32'(i);
    check("R1 nothing pending", 32'h003F003F);

    // R4, R5, R7: every ID alone in slot 0, both classes
    for (int id = 0; id < 40; id++) begin
      clear_all();
      tbl[0] = 32'h8000_0000 | 32'(id);
      put_src(id, 1'b1, 1'b1);
      check(id < 32 ? "R4 fiq single" : "R7 fiq bank1",
            32'h003F_8000 | 32'(id));
      put_src(id, 1'b1, 1'b0);
      check(id < 32 ? "R5 irq single" : "R7 irq bank1",
            32'h8000_003F | (32'(id) << 16));
    end

    // R7: bank-1 bit 8 and up unreachable; ID 33 must use hi bit 1 not lo bit 1
    clear_all();
    tbl[0] = 32'h8000_0021;
    act_lo = 32'h0000_0002; sel_lo = 32'h0000_0002;
    check("R7 bank0 bit not used for id33", 32'h003F003F);

    // R2: valid flag clear blocks a fully active source
    clear_all();
    act_lo = '1; act_hi = '1; sel_lo = 32'h5555_5555; sel_hi = 32'h5555_5555;
    for (int i = 0; i < 40; i++) tbl[i] = 32'(i);
    check("R2 all invalid", 32'h003F003F);

    // R3: IDs 40..63 ignored even with everything pending
    for (int id = 40; id < 64; id++) begin
      clear_all();
      act_lo = '1; act_hi = '1; sel_hi = (id[0]) ? '1 : '0;
      for (int i = 0; i < 40; i++) tbl[i] = 32'h8000_0000 | 32'(id);
      check("R3 id out of range", 32'h003F003F);
    end

    // R6: lowest slot wins; both classes resolved independently
    clear_all();
    tbl[3] = 32'h8000_0005; tbl[7] = 32'h8000_0002;
    tbl[9] = 32'h8000_0024; tbl[20] = 32'h8000_0001;
    put_src(5, 1'b1, 1'b0); put_src(2, 1'b1, 1'b0);
    put_src(36, 1'b1, 1'b1); put_src(1, 1'b1, 1'b1);
    check("R6 independent winners", 32'h8005_8024);
    tbl[3][31] = 1'b0;
    check("R6 next irq slot", 32'h8002_8024);

    // R8: junk in slot bits 30:6 has no effect
    clear_all();
    tbl[4] = 32'hFFFF_FFC0 | 32'd11;
    put_src(11, 1'b1, 1'b1);
    check("R8 junk bits fiq", 32'h003F_800B);
    tbl[4] = 32'h7FFF_FFC0 | 32'd11;
    check("R8 junk without valid", 32'h003F003F);

    // R6, R8: random permutations scored against the scan
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 40; i++) begin
        tbl[i] = $urandom;
        tbl[i][5:0] = 6'($urandom % 46);
      end
      act_lo = $urandom & $urandom; act_hi = $urandom;
      sel_lo = $urandom; sel_hi = $urandom;
      check("R6 random sweep", ref_word());
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule